// File: doc/BRIEF.md
# Bus Error Watcher and Logger

This block sits beside a shared system bus and looks at every completed data transfer. A transfer that arrives with a nonzero three-bit error code is sorted by its code and by the unit that produced it: cache data array, cache tag array or main memory. The matching 8-bit counter is stepped. These counters never wrap and software may load them.

A log holds the code, the transaction ID, the ID of the responding agent and the data word of the most recent erroring transfer. When an unrecoverable code (4 to 7) is logged, the log freezes, so that software can see the first serious fault and not a later one. The freeze lasts until software reads the status register. Two interrupt lines pulse for one cycle: one for correctable events and one for uncorrectable events.

Software reaches the block through a simple register port with four word addresses. The counters fill two 32-bit registers. Writes that do not enable all four byte lanes are dropped, so that no counter is left half updated.

Top module: `bus_err_monitor`

## Requirements
- R1: Each error event steps exactly one of seven counters, chosen as follows.
  - Codes 1 to 3 are correctable. They go to the counter for their source: source 0 is cache data, source 1 is cache tag, and sources 2 or 3 are memory.
  - Code 4 is uncorrectable ECC. It goes to the uncorrectable counter for its source.
  - Codes 5, 6 and 7 all go to the bus/fatal counter, whatever the source.
  - Address 2 reads {tag-uncorr, tag-corr, data-uncorr, data-corr} from bits 31 down to 0, one byte each.
  - Address 3 reads {8'h00, bus/fatal, mem-uncorr, mem-corr}.
- R2: A counter at 0xFF stays at 0xFF when another event arrives for it.
- R3: A write with reg_wstrb = 4'hF to address 2 or 3 loads every counter in that register from its byte lane, and a zero byte clears its counter. A load takes priority over an increment in the same cycle.
- R4: A register write whose strobe is not 4'hF changes no counter.
- R5: While the log is not frozen, an event (xfer_vld high and code nonzero) is captured into the log. Address 0 reads the status: code in [2:0], log-valid in [3], frozen in [4], responder ID in [11:8] and transaction ID in [21:12].
- R6: Capturing a code from 4 to 7 sets the frozen state. While frozen, later events are still counted but do not change the log.
- R7: Address 1 returns the data word captured with the logged event.
- R8: A read (reg_rd high) of address 0 clears the frozen state. If an event arrives in that same cycle, it is captured, and it freezes the log again when its code is 4 to 7.
- R9: cor_irq is high in the cycle after each event with code 1 to 3. unc_irq is high in the cycle after each event with code 4 to 7. This holds even when the counter is saturated.
- R10: A transfer with xfer_vld low, or with code 0, changes no counter, no log field and no interrupt.
- R11: After reset all counters, log fields, the frozen state and both interrupts read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_vld | input | 1 | Transfer completed this cycle |
| xfer_code | input | 3 | Error code returned with the transfer |
| xfer_src | input | 2 | Error source: 0 cache data, 1 cache tag, 2/3 memory |
| xfer_tid | input | TID_W | Transaction ID (top 4 bits = initiating agent) |
| xfer_rid | input | RID_W | Responding agent number |
| xfer_data | input | DATA_W | Data word returned with the transfer |
| reg_addr | input | 2 | Register word address |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wstrb | input | 4 | Byte-lane write enables |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| cor_irq | output | 1 | Correctable-error interrupt pulse |
| unc_irq | output | 1 | Uncorrectable-error interrupt pulse |

## Verification
The bench uses the default parameters: a 10-bit transaction ID, a 4-bit responder ID and a 32-bit data word. With these, every status field has its own bit range and can be checked on its own. Because the counters are 8 bits wide, a counter can be preloaded to 0xFE through the register port, so saturation takes only a few events. The bench also runs a random phase that mixes freezes, releases, partial writes and increments in the same cycle.

// File: rtl/berr_pkg.sv
package berr_pkg;
  localparam int CNT_W       = 8;
  localparam int NUM_CNT     = 7;
  localparam int CACHE_SLOTS = 4;
  localparam logic [2:0] BUS_SLOT = 3'd6;

  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_DATA   = 2'd1;
  localparam logic [1:0] A_CACHE  = 2'd2;
  localparam logic [1:0] A_MEMBUS = 2'd3;

  // Codes 4..7 lock the log
  function automatic logic code_unrec(input logic [2:0] c);
    return c[2];
  endfunction

  function automatic logic code_cor(input logic [2:0] c);
    return (c != 3'd0) && !c[2];
  endfunction

  // Counter slot for an event: pairs (corr, uncorr) per source, bus/fatal last
  function automatic logic [2:0] slot_of(input logic [2:0] c, input logic [1:0] src);
    logic [2:0] base;
    if (c[2] && (c != 3'd4)) return BUS_SLOT;
    case (src)
      2'd0:    base = 3'd0;
      2'd1:    base = 3'd2;
      default: base = 3'd4;
    endcase
    return base + {2'b00, c[2]};
  endfunction

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] q);
    return (&q) ? q : q + 1'b1;
  endfunction
endpackage

// File: rtl/berr_classify.sv
module berr_classify
  import berr_pkg::*;
(
  input  logic               vld,
  input  logic [2:0]         code,
  input  logic [1:0]         src,
  output logic               ev,
  output logic               ev_cor,
  output logic               ev_unc,
  output logic [NUM_CNT-1:0] inc_vec
);
  logic [2:0] slot;

  assign ev     = vld && (code != 3'd0);
  assign ev_cor = vld && code_cor(code);
  assign ev_unc = vld && code_unrec(code);
  assign slot   = slot_of(code, src);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
    assign inc_vec[i] = ev && (slot == 3'(i));
  end

  always_comb begin
    // R1
    inc_onehot_chk: assert ($onehot0(inc_vec));
  end
endmodule

// File: rtl/berr_sat_counter.sv
module berr_sat_counter #(
  parameter int W = berr_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= berr_pkg::sat_step(q);
  end

  // R2
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&q) && !ld) |=> (&q));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !inc) |=> $stable(q));
endmodule

// File: rtl/berr_log.sv
module berr_log #(
  parameter int TID_W  = 10,
  parameter int RID_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev,
  input  logic [2:0]        code,
  input  logic [TID_W-1:0]  tid,
  input  logic [RID_W-1:0]  rid,
  input  logic [DATA_W-1:0] data,
  input  logic              rd_status,
  output logic [2:0]        log_code,
  output logic [TID_W-1:0]  log_tid,
  output logic [RID_W-1:0]  log_rid,
  output logic [DATA_W-1:0] log_data,
  output logic              log_vld,
  output logic              frozen,
  output logic              cap
);
  assign cap = ev && (!frozen || rd_status);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_code <= '0;
      log_tid  <= '0;
      log_rid  <= '0;
      log_data <= '0;
      log_vld  <= 1'b0;
      frozen   <= 1'b0;
    end else if (cap) begin
      log_code <= code;
      log_tid  <= tid;
      log_rid  <= rid;
      log_data <= data;
      log_vld  <= 1'b1;
      frozen   <= berr_pkg::code_unrec(code);
    end else if (rd_status) begin
      frozen   <= 1'b0;
    end
  end

  // R6
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !rd_status) |=> ($stable(log_code) && $stable(log_tid) &&
                                $stable(log_rid) && $stable(log_data) && frozen));

  // R8
  refreeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && rd_status && code[2]) |=> (frozen && log_code == $past(code)));
endmodule

// File: rtl/bus_err_monitor.sv
module bus_err_monitor
  import berr_pkg::*;
#(
  parameter int TID_W  = 10,
  parameter int RID_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_vld,
  input  logic [2:0]        xfer_code,
  input  logic [1:0]        xfer_src,
  input  logic [TID_W-1:0]  xfer_tid,
  input  logic [RID_W-1:0]  xfer_rid,
  input  logic [DATA_W-1:0] xfer_data,
  input  logic [1:0]        reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [3:0]        reg_wstrb,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cor_irq,
  output logic              unc_irq
);
  localparam int ST_VLD  = 3;
  localparam int ST_FRZ  = 4;
  localparam int ST_RID  = 8;
  localparam int ST_TID  = ST_RID + RID_W;

  logic               ev, ev_cor, ev_unc;
  logic [NUM_CNT-1:0] inc_vec;
  logic               full_wr, ld_cache, ld_mem, rd_status;
  logic [CNT_W-1:0]   cnt [NUM_CNT];

  logic [2:0]         log_code;
  logic [TID_W-1:0]   log_tid;
  logic [RID_W-1:0]   log_rid;
  logic [DATA_W-1:0]  log_data;
  logic               log_vld, frozen, cap;
  logic [31:0]        status_w, data_w, cache_w, mem_w;

  berr_classify u_cls (
    .vld(xfer_vld), .code(xfer_code), .src(xfer_src),
    .ev(ev), .ev_cor(ev_cor), .ev_unc(ev_unc), .inc_vec(inc_vec)
  );

  assign full_wr   = reg_wr && (&reg_wstrb);
  assign ld_cache  = full_wr && (reg_addr == A_CACHE);
  assign ld_mem    = full_wr && (reg_addr == A_MEMBUS);
  assign rd_status = reg_rd && (reg_addr == A_STATUS);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    if (i < CACHE_SLOTS) begin : g_cache
      berr_sat_counter #(.W(CNT_W)) u_c (
        .clk(clk), .rst_n(rst_n), .inc(inc_vec[i]), .ld(ld_cache),
        .ld_val(reg_wdata[CNT_W*i +: CNT_W]), .q(cnt[i])
      );
    end else begin : g_mem
      berr_sat_counter #(.W(CNT_W)) u_c (
        .clk(clk), .rst_n(rst_n), .inc(inc_vec[i]), .ld(ld_mem),
        .ld_val(reg_wdata[CNT_W*(i-CACHE_SLOTS) +: CNT_W]), .q(cnt[i])
      );
    end
  end

  berr_log #(.TID_W(TID_W), .RID_W(RID_W), .DATA_W(DATA_W)) u_log (
    .clk(clk), .rst_n(rst_n), .ev(ev), .code(xfer_code),
    .tid(xfer_tid), .rid(xfer_rid), .data(xfer_data), .rd_status(rd_status),
    .log_code(log_code), .log_tid(log_tid), .log_rid(log_rid),
    .log_data(log_data), .log_vld(log_vld), .frozen(frozen), .cap(cap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cor_irq <= 1'b0;
      unc_irq <= 1'b0;
    end else begin
      cor_irq <= ev_cor;
      unc_irq <= ev_unc;
    end
  end

  always_comb begin
    status_w = '0;
    status_w[2:0]              = log_code;
    status_w[ST_VLD]           = log_vld;
    status_w[ST_FRZ]           = frozen;
    status_w[ST_RID +: RID_W]  = log_rid;
    status_w[ST_TID +: TID_W]  = log_tid;
    data_w  = 32'(log_data);
    cache_w = {cnt[3], cnt[2], cnt[1], cnt[0]};
    mem_w   = {8'h00, cnt[6], cnt[5], cnt[4]};
  end

  always_comb begin
    case (reg_addr)
      A_STATUS: reg_rdata = status_w;
      A_DATA:   reg_rdata = data_w;
      A_CACHE:  reg_rdata = cache_w;
      default:  reg_rdata = mem_w;
    endcase
  end

  // R9
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cor_irq && unc_irq));

  // R4
  partial_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !(&reg_wstrb) && !ev) |=> ($stable(cache_w) && $stable(mem_w)));

  // R5
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (log_vld && log_tid == $past(xfer_tid) && log_rid == $past(xfer_rid)));
endmodule

// File: tb/bus_err_monitor_test.sv
module bus_err_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_vld = 1'b0;
  logic [2:0]  xfer_code = '0;
  logic [1:0]  xfer_src = '0;
  logic [9:0]  xfer_tid = '0;
  logic [3:0]  xfer_rid = '0;
  logic [31:0] xfer_data = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_wstrb = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cor_irq, unc_irq;

  always #5 clk = ~clk;

  bus_err_monitor uut (
    .clk(clk), .rst_n(rst_n), .xfer_vld(xfer_vld), .xfer_code(xfer_code),
    .xfer_src(xfer_src), .xfer_tid(xfer_tid), .xfer_rid(xfer_rid),
    .xfer_data(xfer_data), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wstrb(reg_wstrb), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cor_irq(cor_irq), .unc_irq(unc_irq)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Reference state
  int          m_cnt[7];
  bit [2:0]    m_code;
  bit [9:0]    m_tid;
  bit [3:0]    m_rid;
  bit [31:0]   m_data;
  bit          m_vld, m_frz, m_cirq, m_uirq;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // Which counter an event lands in, from the R1 mapping
  function automatic int target(bit [2:0] c, bit [1:0] s);
    int grp;
    if (c >= 5) return 6;
    grp = (s == 0) ? 0 : (s == 1) ? 1 : 2;
    return grp * 2 + ((c == 4) ? 1 : 0);
  endfunction

  function automatic logic [31:0] expect_rd(bit [1:0] a);
    case (a)
      2'd0: return {10'd0, m_tid, m_rid, 3'd0, m_frz, m_vld, m_code};
      2'd1: return m_data;
      2'd2: return {m_cnt[3][7:0], m_cnt[2][7:0], m_cnt[1][7:0], m_cnt[0][7:0]};
      default: return {8'd0, m_cnt[6][7:0], m_cnt[5][7:0], m_cnt[4][7:0]};
    endcase
  endfunction

  task automatic model_step();
    bit rd_st = reg_rd && (reg_addr == 2'd0);
    bit ev    = xfer_vld && (xfer_code != 0);
    bit fw    = reg_wr && (reg_wstrb == 4'hF);
    int s     = ev ? target(xfer_code, xfer_src) : -1;
    for (int k = 0; k < 7; k++) begin
      bit ldk = fw && ((k < 4 && reg_addr == 2'd2) || (k >= 4 && reg_addr == 2'd3));
      if (ldk) m_cnt[k] = int'((reg_wdata >> (8 * (k % 4))) & 32'hFF);
      else if (k == s && m_cnt[k] < 255) m_cnt[k] = m_cnt[k] + 1;
    end
    if (ev && (!m_frz || rd_st)) begin
      m_code = xfer_code; m_tid = xfer_tid; m_rid = xfer_rid;
      m_data = xfer_data; m_vld = 1; m_frz = (xfer_code >= 4);
    end else if (rd_st) m_frz = 0;
    m_cirq = ev && (xfer_code < 4);
    m_uirq = ev && (xfer_code >= 4);
  endtask

  // One clock: model follows the edge, outputs compared at the falling edge
  task automatic cycle(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, "cor_irq", {31'd0, cor_irq}, {31'd0, m_cirq});
    chk(tag, "unc_irq", {31'd0, unc_irq}, {31'd0, m_uirq});
    chk(tag, $sformatf("rdata@%0d", reg_addr), reg_rdata, expect_rd(reg_addr));
  endtask

  task automatic idle();
    xfer_vld = 0; reg_rd = 0; reg_wr = 0; reg_wstrb = 0;
  endtask

  task automatic event_in(string tag, bit [2:0] c, bit [1:0] s, bit [9:0] t,
                          bit [3:0] r, bit [31:0] d);
    xfer_vld = 1; xfer_code = c; xfer_src = s; xfer_tid = t; xfer_rid = r; xfer_data = d;
    cycle(tag);
    idle();
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      cycle(tag);
    end
  endtask

  task automatic wr(string tag, bit [1:0] a, bit [3:0] st, bit [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wstrb = st; reg_wdata = d;
    cycle(tag);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 7; k++) m_cnt[k] = 0;
    repeat (3) @(negedge clk);
    // R11: reset state on every register
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #1 chk("R11", "reset rdata", reg_rdata, 32'h0);
    end
    chk("R11", "reset irqs", {30'd0, cor_irq, unc_irq}, 32'h0);
    rst_n = 1;

    // R10: code 0 and strobe-low transfers change nothing
    event_in("R10", 3'd0, 2'd0, 10'h155, 4'h3, 32'hDEAD_0000);
    xfer_code = 3'd4; xfer_tid = 10'h0AA;
    cycle("R10");
    sweep("R10");

    // R1/R5: correctable codes from each source
    event_in("R5", 3'd1, 2'd0, 10'h3C1, 4'h1, 32'h1111_0001);
    event_in("R1", 3'd2, 2'd1, 10'h012, 4'h2, 32'h2222_0002);
    event_in("R1", 3'd3, 2'd2, 10'h245, 4'h5, 32'h3333_0003);
    event_in("R1", 3'd1, 2'd3, 10'h2F0, 4'h6, 32'h4444_0004);
    sweep("R1");

    // R6: uncorrectable freezes; later events counted, not logged
    event_in("R6", 3'd4, 2'd0, 10'h301, 4'h9, 32'hBAD0_0001);
    event_in("R6", 3'd1, 2'd2, 10'h111, 4'h4, 32'h5555_5555);
    event_in("R6", 3'd5, 2'd1, 10'h0F0, 4'h7, 32'h6666_6666);
    sweep("R6");
    reg_addr = 2'd1; cycle("R7");
    // R8: status read releases, next event logged
    reg_addr = 2'd0; reg_rd = 1; cycle("R8"); idle();
    event_in("R8", 3'd2, 2'd1, 10'h077, 4'hB, 32'h7777_0007);
    sweep("R7");

    // R8: release and unrecoverable event in the same cycle re-freezes
    event_in("R8", 3'd5, 2'd2, 10'h1A1, 4'hC, 32'hAAAA_0005);
    reg_addr = 2'd0; reg_rd = 1;
    xfer_vld = 1; xfer_code = 3'd6; xfer_src = 2'd0; xfer_tid = 10'h2B2;
    xfer_rid = 4'hD; xfer_data = 32'hBBBB_0006;
    cycle("R8"); idle();
    event_in("R8", 3'd1, 2'd0, 10'h3FF, 4'hE, 32'hCCCC_0001);
    sweep("R8");
    reg_addr = 2'd0; reg_rd = 1; cycle("R8"); idle();
    event_in("R8", 3'd7, 2'd3, 10'h004, 4'hF, 32'hDDDD_0007);
    sweep("R8");

    // R3: full writes load and clear; load beats same-cycle increment
    wr("R3", 2'd2, 4'hF, 32'h0102_0304);
    wr("R3", 2'd3, 4'hF, 32'h0);
    sweep("R3");
    xfer_vld = 1; xfer_code = 3'd1; xfer_src = 2'd0;
    wr("R3", 2'd2, 4'hF, 32'h0A0B_0C0D);
    sweep("R3");

    // R4: partial strobes ignored
    wr("R4", 2'd2, 4'h7, 32'hFFFF_FFFF);
    wr("R4", 2'd3, 4'h1, 32'h0000_00FF);
    sweep("R4");

    // R2/R9: saturation, interrupt still pulses
    wr("R2", 2'd2, 4'hF, 32'hFEFE_FEFE);
    wr("R2", 2'd3, 4'hF, 32'h00FE_FEFE);
    for (int n = 0; n < 3; n++) begin
      event_in("R2", 3'd4, 2'd0, 10'h100, 4'h1, 32'h0);
      event_in("R9", 3'd3, 2'd1, 10'h101, 4'h2, 32'h1);
      event_in("R9", 3'd6, 2'd2, 10'h102, 4'h3, 32'h2);
    end
    sweep("R2");

    // R1: random mixture
    for (int n = 0; n < 600; n++) begin
      xfer_vld  = ($urandom_range(0, 3) != 0);
      xfer_code = 3'($urandom_range(0, 7));
      xfer_src  = 2'($urandom_range(0, 3));
      xfer_tid  = 10'($urandom);
      xfer_rid  = 4'($urandom);
      xfer_data = $urandom;
      reg_addr  = 2'($urandom_range(0, 3));
      reg_rd    = ($urandom_range(0, 4) == 0);
      reg_wr    = ($urandom_range(0, 9) == 0);
      reg_wstrb = ($urandom_range(0, 1) == 0) ? 4'hF : 4'($urandom);
      reg_wdata = $urandom;
      cycle("R1");
    end
    idle();
    sweep("R1");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule